// File: doc/BRIEF.md
# Circular Reorder Buffer

This block keeps the results of speculatively executed instructions in program order until they can be made architectural. It is a ring of twelve slots with a head and a tail pointer. The front end places each instruction at the tail. The slot index it receives is the tag that names its pending result. Execution units return results by tag in any order. The oldest slot leaves through the head only after its result has arrived.

A later instruction can read a completed but not yet retired result by tag, which makes the buffer an operand source alongside the register file. When a branch turns out to be mispredicted or an exception is raised, one flush cycle discards every slot in flight. None of the discarded slots ever reaches the commit port.

Top module: `rob_ring`

## Requirements
- R1: While and just after reset the buffer is empty: `alloc_ready` is 1, `cm_valid` is 0 and `alloc_tag` is 0.
- R2: An accepted allocation (`alloc_req`=1, `alloc_ready`=1, `flush`=0) is given the tag shown on `alloc_tag` in that cycle. Successive accepted allocations receive consecutive tags, and tag 11 is followed by tag 0.
- R3: With 12 slots outstanding, `alloc_ready` is 0. A request made in that state is not taken and `alloc_tag` does not move.
- R4: `cm_valid` is 1 only when the head slot is allocated and its result has been written, at the earliest in the cycle after the writeback. Slots retire one per cycle in allocation order, and `cm_tag` gives the head index.
- R5: A retiring slot presents the instruction field, the destination and the last value written to it on `cm_op`, `cm_dst` and `cm_val`.
- R6: A writeback whose tag names a free slot, or a tag of 12 or more, is ignored. If that slot is later allocated, it reads as not ready and does not retire until it is written again.
- R7: The read port drives `rd_ready`=1 and the stored result on `rd_val` when the slot named by `rd_tag` is allocated and written. It drives `rd_ready`=0 when the slot is allocated but not yet written.
- R8: A writeback in the current cycle to the slot named by `rd_tag` is forwarded to `rd_ready`/`rd_val` in that same cycle.
- R9: In a `flush` cycle, `cm_valid` is 0 and no allocation is taken. In the next cycle the buffer is empty and `alloc_tag` equals the head index from before the flush. Discarded slots read as not ready and never retire.
- R10: An allocation and a retirement in the same cycle both take effect. When the buffer is full, the allocation is refused even in a cycle that retires a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all slots in flight |
| alloc_req | input | 1 | Request a slot at the tail |
| alloc_op | input | OP_W | Instruction field stored with the slot |
| alloc_dst | input | DST_W | Destination register number |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TAG_W | Tag given to an allocation in this cycle |
| wb_en | input | 1 | Result writeback strobe |
| wb_tag | input | TAG_W | Slot receiving the result |
| wb_val | input | VAL_W | Result value |
| rd_tag | input | TAG_W | Slot looked up for an operand |
| rd_ready | output | 1 | Looked-up result is available |
| rd_val | output | VAL_W | Looked-up result value |
| cm_valid | output | 1 | Head slot retires at this clock edge |
| cm_tag | output | TAG_W | Index of the head slot |
| cm_op | output | OP_W | Instruction field of the head slot |
| cm_dst | output | DST_W | Destination of the head slot |
| cm_val | output | VAL_W | Result of the head slot |

## Verification
The hardest state to reach is a completely full ring whose head sits in the middle of the array. In that state, retirement and a new allocation meet in the same cycle while both pointers wrap. The stimulus first retires three slots so that the head moves off zero. It then fills all twelve slots and writes their results in reverse order, so nothing can retire until the head itself is written. Allocations are offered during the drain, starting in the cycle when the ring is still full. A flush is also issued in the cycle when the head result has just become complete, which is the one moment when suppressing retirement is visible.

// File: rtl/rob_ring.sv
module rob_ring #(
  parameter int DEPTH = 12,
  parameter int OP_W  = 8,
  parameter int DST_W = 5,
  parameter int VAL_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_req,
  input  logic [OP_W-1:0]  alloc_op,
  input  logic [DST_W-1:0] alloc_dst,
  output logic             alloc_ready,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             wb_en,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [VAL_W-1:0] wb_val,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_ready,
  output logic [VAL_W-1:0] rd_val,
  output logic             cm_valid,
  output logic [TAG_W-1:0] cm_tag,
  output logic [OP_W-1:0]  cm_op,
  output logic [DST_W-1:0] cm_dst,
  output logic [VAL_W-1:0] cm_val
);

  function automatic logic [TAG_W-1:0] step_ptr(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] busy_q, done_q;
  logic [OP_W-1:0]  op_q  [DEPTH];
  logic [DST_W-1:0] dst_q [DEPTH];
  logic [VAL_W-1:0] val_q [DEPTH];

  logic alloc_fire, cm_fire, wb_hit, wb_in, rd_in, rd_fwd;

  assign wb_in  = {1'b0, wb_tag} < (TAG_W + 1)'(DEPTH);
  assign rd_in  = {1'b0, rd_tag} < (TAG_W + 1)'(DEPTH);
  assign wb_hit = wb_en && wb_in && busy_q[wb_tag];
  assign rd_fwd = wb_hit && (wb_tag == rd_tag);

  assign alloc_ready = cnt_q != CNT_W'(DEPTH);
  assign alloc_tag   = tail_q;
  assign alloc_fire  = alloc_req && alloc_ready && !flush;

  assign cm_valid = (cnt_q != '0) && done_q[head_q] && !flush;
  assign cm_fire  = cm_valid;
  assign cm_tag   = head_q;
  assign cm_op    = op_q[head_q];
  assign cm_dst   = dst_q[head_q];
  assign cm_val   = val_q[head_q];

  assign rd_ready = rd_in && busy_q[rd_tag] && (done_q[rd_tag] || rd_fwd);
  assign rd_val   = rd_fwd ? wb_val : val_q[rd_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      busy_q <= '0;
      done_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
      cnt_q  <= '0;
      busy_q <= '0;
      done_q <= '0;
    end else begin
      if (alloc_fire) begin
        tail_q         <= step_ptr(tail_q);
        busy_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
      end
      if (wb_hit)
        done_q[wb_tag] <= 1'b1;
      if (cm_fire) begin
        head_q         <= step_ptr(head_q);
        busy_q[head_q] <= 1'b0;
      end
      cnt_q <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(cm_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      op_q[tail_q]  <= alloc_op;
      dst_q[tail_q] <= alloc_dst;
    end
    if (wb_hit)
      val_q[wb_tag] <= wb_val;
  end

endmodule

module rob_ring_chk #(
  parameter int DEPTH = 12,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_req,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             cm_valid,
  input logic [TAG_W-1:0] cm_tag
);

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ready && !flush) |=> alloc_tag == nxt($past(alloc_tag)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush) |=> alloc_tag == $past(alloc_tag));

  p_commit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> cm_tag == nxt($past(cm_tag)));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !cm_valid);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !cm_valid && alloc_tag == $past(cm_tag)));

endmodule

bind rob_ring rob_ring_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(alloc_req),
  .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .cm_valid(cm_valid), .cm_tag(cm_tag)
);

// File: tb/tb_rob_ring.sv
module tb_rob_ring;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, flush = 0;
  logic        alloc_req = 0, wb_en = 0;
  logic [7:0]  alloc_op = 0;
  logic [4:0]  alloc_dst = 0;
  logic [3:0]  wb_tag = 0, rd_tag = 0;
  logic [31:0] wb_val = 0;
  logic        alloc_ready, rd_ready, cm_valid;
  logic [3:0]  alloc_tag, cm_tag;
  logic [31:0] rd_val, cm_val;
  logic [7:0]  cm_op;
  logic [4:0]  cm_dst;

  rob_ring dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(alloc_req), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_val(wb_val),
    .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_val(rd_val),
    .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_op(cm_op),
    .cm_dst(cm_dst), .cm_val(cm_val)
  );

  always #(PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [3:0] tag;
    logic [4:0] dst;
    logic [7:0] op;
  } exp_t;

  exp_t        q[$];
  logic [31:0] exp_val [16];
  logic [15:0] busy_m = '0;
  int          tests = 0, fails = 0;
  bit          done_f = 0;
  logic        got_ready;
  logic [3:0]  got_tag;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(bit a, logic [4:0] d, logic [7:0] o,
                       bit w, logic [3:0] wt, logic [31:0] wv, bit f);
    @(negedge clk);
    alloc_req = a; alloc_dst = d; alloc_op = o;
    wb_en = w; wb_tag = wt; wb_val = wv; flush = f;
    #1;
    got_ready = alloc_ready;
    got_tag   = alloc_tag;
    if (f) begin
      q.delete();
      busy_m = '0;
    end else begin
      if (w && busy_m[wt]) exp_val[wt] = wv;
      if (a && alloc_ready) begin
        q.push_back('{tag: alloc_tag, dst: d, op: o});
        busy_m[alloc_tag] = 1'b1;
      end
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q.size() != 0; i++) idle();
    chk("R4 all expected slots retired", q.size(), 0);
  endtask

  // monitor: pops the scoreboard as slots retire
  initial forever begin
    exp_t e;
    @(negedge clk);
    #(PERIOD / 4);
    if (rst_n && cm_valid) begin
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 unexpected retirement: got tag %0h expected none", cm_tag);
      end else begin
        e = q.pop_front();
        chk("R4 retirement order tag", cm_tag, e.tag);
        chk("R5 retired dst", cm_dst, e.dst);
        chk("R5 retired op", cm_op, e.op);
        chk("R5 retired value", cm_val, exp_val[e.tag]);
        busy_m[e.tag] = 1'b0;
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done_f) begin
      tests++; fails++;
      $display("FAIL R4 watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 alloc_ready in reset", alloc_ready, 1);
    chk("R1 cm_valid in reset", cm_valid, 0);
    chk("R1 alloc_tag in reset", alloc_tag, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 alloc_tag after reset", alloc_tag, 0);

    // out-of-order completion, read port and forwarding
    for (int i = 0; i < 3; i++) begin
      drive(1, 5'(i + 1), 8'(8'h11 + i), 0, 0, 0, 0);
      chk("R2 consecutive tag", got_tag, i);
    end
    drive(0, 0, 0, 1, 4'd2, 32'hA2, 0);
    chk("R4 head unwritten, no retirement", cm_valid, 0);
    drive(0, 0, 0, 1, 4'd1, 32'hA1, 0);
    chk("R4 younger written, head not", cm_valid, 0);
    rd_tag = 4'd2; #1;
    chk("R7 written slot ready", rd_ready, 1);
    chk("R7 written slot value", rd_val, 32'hA2);
    rd_tag = 4'd0; #1;
    chk("R7 unwritten slot not ready", rd_ready, 0);
    drive(0, 0, 0, 1, 4'd0, 32'hA0, 0);
    chk("R8 forwarded ready", rd_ready, 1);
    chk("R8 forwarded value", rd_val, 32'hA0);
    chk("R4 no retirement in writeback cycle", cm_valid, 0);
    drain();

    // fill with head at 3, wrap of both pointers
    for (int i = 0; i < 12; i++) begin
      drive(1, 5'(i), 8'(8'h20 + i), 0, 0, 0, 0);
      chk("R2 tag with wrap", got_tag, (3 + i) % 12);
    end
    drive(1, 5'd30, 8'h99, 0, 0, 0, 0);
    chk("R3 full refuses", got_ready, 0);
    idle();
    chk("R3 tail unchanged when full", alloc_tag, 3);
    chk("R4 nothing written, no retirement", cm_valid, 0);
    for (int i = 11; i >= 0; i--)
      drive(0, 0, 0, 1, 4'((3 + i) % 12), 32'hB000 + i, 0);
    drive(1, 5'd17, 8'h40, 0, 0, 0, 0);
    chk("R10 full refuses during retirement", got_ready, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1, 5'(18 + i), 8'(8'h41 + i), 0, 0, 0, 0);
      chk("R10 alloc during retirement accepted", got_ready, 1);
      chk("R10 alloc tag during retirement", got_tag, 3 + i);
    end
    for (int i = 0; i < 3; i++)
      drive(0, 0, 0, 1, 4'(3 + i), 32'hC300 + i, 0);
    drain();

    // ignored writebacks; head = tail = 6
    drive(0, 0, 0, 1, 4'd6, 32'hDEAD, 0);
    drive(0, 0, 0, 1, 4'd14, 32'hBEEF, 0);
    drive(1, 5'd9, 8'h66, 0, 0, 0, 0);
    chk("R6 realloc tag", got_tag, 6);
    rd_tag = 4'd6; #1;
    chk("R6 stale write not seen", rd_ready, 0);
    idle();
    chk("R6 no retirement from stale write", cm_valid, 0);
    drive(0, 0, 0, 1, 4'd6, 32'hC6C6, 0);
    drain();

    // flush with completed head; head = tail = 7
    for (int i = 0; i < 4; i++) drive(1, 5'(i + 24), 8'(8'h70 + i), 0, 0, 0, 0);
    drive(0, 0, 0, 1, 4'd9, 32'hD9, 0);
    drive(0, 0, 0, 1, 4'd7, 32'hD7, 0);
    drive(1, 5'd1, 8'h01, 0, 0, 0, 1);
    chk("R9 no retirement in flush cycle", cm_valid, 0);
    idle();
    chk("R9 empty after flush", alloc_ready, 1);
    chk("R9 tail back at head", alloc_tag, 7);
    chk("R9 nothing retires after flush", cm_valid, 0);
    rd_tag = 4'd9; #1;
    chk("R9 discarded result not readable", rd_ready, 0);
    drive(1, 5'd2, 8'h82, 0, 0, 0, 0);
    chk("R9 alloc after flush tag", got_tag, 7);
    drive(1, 5'd3, 8'h83, 0, 0, 0, 0);
    idle();
    chk("R9 reused slot waits for new result", cm_valid, 0);
    drive(0, 0, 0, 1, 4'd7, 32'hE7, 0);
    drive(0, 0, 0, 1, 4'd8, 32'hE8, 0);
    drain();

    done_f = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule